// File: doc/BRIEF.md
# Suspendable Sequential Integer Divider

This block is the division unit of a 16-bit processor datapath. It divides either a 32-bit or a 16-bit dividend by a 16-bit divisor, in two's-complement or unsigned arithmetic. It returns a 16-bit quotient, a 16-bit remainder and an error flag. The core is a restoring divider that resolves one quotient bit per clock. One setup cycle comes before the sixteen bit steps, and two finishing cycles come after them. Every operation therefore takes a fixed 19 working cycles.

The processor can take an interrupt in the middle of a division. While `suspend_i` is high, the operation stops exactly where it is and keeps its partial remainder, partial quotient and step position. When `suspend_i` falls, the operation continues from the same point. Suspended cycles do not count toward the 19. A start request that arrives while an operation is running is dropped. Results stay on the outputs until the next operation finishes.

Top module: `seq_divider`

## Requirements
- R1: With `wide_i`=1 and `signed_i`=0, the full 32-bit `dividend_i` is divided by `divisor_i` as unsigned numbers. `quot_o` is floor(dividend/divisor) and `rem_o` is the rest.
- R2: With `wide_i`=0, only `dividend_i[15:0]` is used: zero-extended when unsigned, sign-extended when signed. `dividend_i[31:16]` has no effect on any output.
- R3: With `signed_i`=1, both operands are two's complement. The quotient is truncated toward zero, so its sign is the XOR of the two operand signs. The remainder has the sign of the dividend, and quotient × divisor + remainder = dividend.
- R4: A start is accepted on a rising edge where `start_i`=1 and `busy_o`=0. From the next cycle, `busy_o` is 1. `done_o` is a one-cycle pulse that rises on the 19th non-suspended edge after the accepting edge. On that same edge `busy_o` falls and `quot_o`, `rem_o` and `err_o` take their new values.
- R5: On any edge where `busy_o`=1 and `suspend_i`=1, the operation does not advance. Each such cycle delays `done_o` by one cycle and leaves the result unchanged.
- R6: A divisor of zero gives `err_o`=1 at done. In that case `quot_o` and `rem_o` are undefined.
- R7: If the true quotient is outside 0..65535 (unsigned) or −32768..32767 (signed), `err_o`=1 at done and `quot_o`/`rem_o` are undefined. Otherwise `err_o`=0.
- R8: `start_i` while `busy_o`=1 is ignored: the running operation keeps its captured operands and its timing.
- R9: After reset, `busy_o`, `done_o`, `err_o`, `quot_o` and `rem_o` are all 0. `quot_o`, `rem_o` and `err_o` hold their values until the next done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, taken only when idle |
| wide_i | input | 1 | 1: 32-bit dividend, 0: 16-bit dividend |
| signed_i | input | 1 | 1: two's-complement, 0: unsigned |
| suspend_i | input | 1 | Freeze the running operation |
| dividend_i | input | 32 | Dividend, sampled at start |
| divisor_i | input | 16 | Divisor, sampled at start |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| quot_o | output | 16 | Quotient |
| rem_o | output | 16 | Remainder |
| err_o | output | 1 | Divide-by-zero or quotient overflow |

## Verification
The unsigned wide cases reach the largest quotient that still fits (65535² / 65535), so an off-by-one in the overflow test shows up. The narrow-mode cases put noise in the upper dividend half, which separates correct extension from accidental use of those bits. The signed cases cover all four sign combinations and the −32768 / −1 and 32768 / −1 pair, which tells the magnitude range check apart from a plain bit-15 test. Irregular suspend masks and start pulses during a run show whether suspension only stretches time and whether a late start can disturb the captured operands.

// File: rtl/div_pkg.sv
package div_pkg;
  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_SETUP = 3'd1,
    PH_STEP  = 3'd2,
    PH_FIX   = 3'd3,
    PH_SIGN  = 3'd4
  } phase_e;

  // non-step cycles: setup, remainder fix, sign correction
  localparam int unsigned EXTRA_CYCLES = 3;
endpackage

// File: rtl/div_operand_prep.sv
module div_operand_prep #(
  parameter int unsigned W = 16
) (
  input  logic [2*W-1:0] dividend,
  input  logic [W-1:0]   divisor,
  input  logic           wide,
  input  logic           sgn,
  output logic [2*W-1:0] mag_a,
  output logic [W:0]     mag_d,
  output logic           neg_q,
  output logic           neg_r,
  output logic           d_zero
);
  logic [2*W-1:0] ext_a;
  logic [W:0]     ext_d;
  logic           a_neg;
  logic           d_neg;

  always_comb begin
    if (wide) begin
      ext_a = dividend;
    end else if (sgn) begin
      ext_a = {{W{dividend[W-1]}}, dividend[W-1:0]};
    end else begin
      ext_a = {{W{1'b0}}, dividend[W-1:0]};
    end
    a_neg  = sgn & ext_a[2*W-1];
    d_neg  = sgn & divisor[W-1];
    ext_d  = {d_neg, divisor};
    mag_a  = a_neg ? (~ext_a + 1'b1) : ext_a;
    mag_d  = d_neg ? (~ext_d + 1'b1) : ext_d;
    neg_q  = a_neg ^ d_neg;
    neg_r  = a_neg;
    d_zero = (divisor == '0);
  end
endmodule

// File: rtl/div_restore_step.sv
module div_restore_step #(
  parameter int unsigned W = 16
) (
  input  logic [W:0]   part_r,
  input  logic [W-1:0] part_q,
  input  logic [W:0]   dvsr,
  output logic [W:0]   next_r,
  output logic [W-1:0] next_q
);
  logic [W:0] trial;
  logic       fits;

  // part_r stays below 2**W, so its top bit is dropped by the shift
  always_comb begin
    trial  = {part_r[W-1:0], part_q[W-1]};
    fits   = (trial >= dvsr);
    next_r = fits ? (trial - dvsr) : trial;
    next_q = {part_q[W-2:0], fits};
  end

  logic unused_top;
  assign unused_top = part_r[W];
endmodule

// File: rtl/div_sign_fix.sv
module div_sign_fix #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] qmag,
  input  logic [W-1:0] rmag,
  input  logic         neg_q,
  input  logic         neg_r,
  input  logic         sgn,
  output logic [W-1:0] quot,
  output logic [W-1:0] rem,
  output logic         range_err
);
  always_comb begin
    quot = neg_q ? (~qmag + 1'b1) : qmag;
    rem  = neg_r ? (~rmag + 1'b1) : rmag;
    // a signed magnitude may reach 2**(W-1) only when the result is negative
    range_err = sgn & qmag[W-1] & (neg_q ? (|qmag[W-2:0]) : 1'b1);
  end
endmodule

// File: rtl/seq_divider.sv
module seq_divider #(
  parameter int unsigned DATA_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_i,
  input  logic                  wide_i,
  input  logic                  signed_i,
  input  logic                  suspend_i,
  input  logic [2*DATA_W-1:0]   dividend_i,
  input  logic [DATA_W-1:0]     divisor_i,
  output logic                  busy_o,
  output logic                  done_o,
  output logic [DATA_W-1:0]     quot_o,
  output logic [DATA_W-1:0]     rem_o,
  output logic                  err_o
);
  import div_pkg::*;

  localparam int unsigned DVD_W = 2 * DATA_W;
  localparam int unsigned CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(DATA_W - 1);

  // reset: asynchronous assertion, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  // state
  phase_e            phase_q, phase_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [DATA_W:0]   prem_q, prem_d;
  logic [DATA_W-1:0] pquo_q, pquo_d;
  logic [DATA_W:0]   dvsr_q, dvsr_d;
  logic              negq_q, negq_d;
  logic              negr_q, negr_d;
  logic              flag_q, flag_d;
  logic [DVD_W-1:0]  opa_q;
  logic [DATA_W-1:0] opb_q;
  logic              wide_q, sgn_q;
  logic              done_d;

  // clock enables
  logic op_ld;
  logic run_en;
  logic out_ld;

  // datapath wires
  logic [DVD_W-1:0]  mag_a;
  logic [DATA_W:0]   mag_d;
  logic              prep_negq, prep_negr, prep_zero;
  logic [DATA_W:0]   step_r;
  logic [DATA_W-1:0] step_q;
  logic [DATA_W-1:0] fix_quot, fix_rem;
  logic              fix_range;
  logic              hi_ovf;

  div_operand_prep #(.W(DATA_W)) u_prep (
    .dividend (opa_q),
    .divisor  (opb_q),
    .wide     (wide_q),
    .sgn      (sgn_q),
    .mag_a    (mag_a),
    .mag_d    (mag_d),
    .neg_q    (prep_negq),
    .neg_r    (prep_negr),
    .d_zero   (prep_zero)
  );

  div_restore_step #(.W(DATA_W)) u_step (
    .part_r (prem_q),
    .part_q (pquo_q),
    .dvsr   (dvsr_q),
    .next_r (step_r),
    .next_q (step_q)
  );

  div_sign_fix #(.W(DATA_W)) u_fix (
    .qmag      (pquo_q),
    .rmag      (prem_q[DATA_W-1:0]),
    .neg_q     (negq_q),
    .neg_r     (negr_q),
    .sgn       (sgn_q),
    .quot      (fix_quot),
    .rem       (fix_rem),
    .range_err (fix_range)
  );

  assign busy_o = (phase_q != PH_IDLE);
  assign op_ld  = (phase_q == PH_IDLE) & start_i;
  assign run_en = busy_o & ~suspend_i;
  assign out_ld = (phase_q == PH_SIGN) & ~suspend_i;
  // a quotient above 2**DATA_W-1 shows as an upper half not below the divisor
  assign hi_ovf = ({1'b0, mag_a[DVD_W-1:DATA_W]} >= mag_d);

  // next state
  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    prem_d  = prem_q;
    pquo_d  = pquo_q;
    dvsr_d  = dvsr_q;
    negq_d  = negq_q;
    negr_d  = negr_q;
    flag_d  = flag_q;
    done_d  = 1'b0;
    unique case (phase_q)
      PH_IDLE: begin
        if (start_i) phase_d = PH_SETUP;
      end
      PH_SETUP: begin
        phase_d = PH_STEP;
        cnt_d   = '0;
        prem_d  = {1'b0, mag_a[DVD_W-1:DATA_W]};
        pquo_d  = mag_a[DATA_W-1:0];
        dvsr_d  = mag_d;
        negq_d  = prep_negq;
        negr_d  = prep_negr;
        flag_d  = prep_zero | hi_ovf;
      end
      PH_STEP: begin
        prem_d = step_r;
        pquo_d = step_q;
        cnt_d  = cnt_q + 1'b1;
        if (cnt_q == LAST_STEP) phase_d = PH_FIX;
      end
      PH_FIX: begin
        flag_d  = flag_q | fix_range;
        phase_d = PH_SIGN;
      end
      PH_SIGN: begin
        done_d  = 1'b1;
        phase_d = PH_IDLE;
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  // sequencing registers
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      prem_q  <= '0;
      pquo_q  <= '0;
      dvsr_q  <= '0;
      negq_q  <= 1'b0;
      negr_q  <= 1'b0;
      flag_q  <= 1'b0;
    end else if (op_ld | run_en) begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      prem_q  <= prem_d;
      pquo_q  <= pquo_d;
      dvsr_q  <= dvsr_d;
      negq_q  <= negq_d;
      negr_q  <= negr_d;
      flag_q  <= flag_d;
    end
  end

  // operand capture
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      opa_q  <= '0;
      opb_q  <= '0;
      wide_q <= 1'b0;
      sgn_q  <= 1'b0;
    end else if (op_ld) begin
      opa_q  <= dividend_i;
      opb_q  <= divisor_i;
      wide_q <= wide_i;
      sgn_q  <= signed_i;
    end
  end

  // result registers
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      quot_o <= '0;
      rem_o  <= '0;
      err_o  <= 1'b0;
    end else if (out_ld) begin
      quot_o <= fix_quot;
      rem_o  <= fix_rem;
      err_o  <= flag_q;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) done_o <= 1'b0;
    else         done_o <= done_d & run_en;
  end
endmodule

// File: rtl/div_checker.sv
module div_checker #(
  parameter int unsigned W = 16
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   start_i,
  input logic                   suspend_i,
  input logic [W-1:0]           divisor_i,
  input logic                   busy_o,
  input logic                   done_o,
  input logic                   err_o,
  input div_pkg::phase_e        phase_q,
  input logic [$clog2(W)-1:0]   cnt_q
);
  import div_pkg::*;

  localparam int unsigned LAT = W + EXTRA_CYCLES;

  logic [7:0] act_cnt;
  logic       zero_div;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_cnt  <= '0;
      zero_div <= 1'b0;
    end else if (start_i && !busy_o) begin
      act_cnt  <= '0;
      zero_div <= (divisor_i == '0);
    end else if (busy_o && !suspend_i && act_cnt != 8'hFF) begin
      act_cnt <= act_cnt + 8'd1;
    end
  end

  assert_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (act_cnt == 8'(LAT)));

  assert_done_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  assert_busy_from_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(start_i));

  assert_freeze_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && suspend_i) |=> ($stable(phase_q) && $stable(cnt_q)));

  assert_zero_div_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && zero_div) |-> err_o);

  assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> (phase_q != PH_SETUP));
endmodule

bind seq_divider div_checker #(.W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start_i   (start_i),
  .suspend_i (suspend_i),
  .divisor_i (divisor_i),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .err_o     (err_o),
  .phase_q   (phase_q),
  .cnt_q     (cnt_q)
);

// File: tb/sim_seq_divider.sv
module sim_seq_divider;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        wide = 1'b0;
  logic        sgn = 1'b0;
  logic        susp = 1'b0;
  logic [31:0] dvd = '0;
  logic [15:0] dvs = '0;
  logic        busy, done, err;
  logic [15:0] quot, rem;

  always #2 clk = ~clk;

  seq_divider u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start), .wide_i(wide),
    .signed_i(sgn), .suspend_i(susp), .dividend_i(dvd), .divisor_i(dvs),
    .busy_o(busy), .done_o(done), .quot_o(quot), .rem_o(rem), .err_o(err)
  );

  int    n_chk = 0;
  int    n_fail = 0;
  bit    finished = 0;
  string cur_req = "R9";

  // reference model state
  bit          m_act = 0;
  bit          m_busy = 0;
  bit          m_done = 0;
  int          m_left = 0;
  bit          have = 0;
  logic [15:0] p_q, p_r, h_q, h_r;
  bit          p_err, h_err;

  task automatic chk(input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", cur_req, what, act, exp);
    end
  endtask

  function automatic void expect_div(input logic [31:0] a_in, input logic [15:0] b_in,
                                     input bit w, input bit s);
    longint a, b, q, r;
    if (s) begin
      a = w ? longint'($signed(a_in)) : longint'($signed(a_in[15:0]));
      b = longint'($signed(b_in));
    end else begin
      a = w ? longint'(a_in) : longint'(a_in[15:0]);
      b = longint'(b_in);
    end
    if (b == 0) begin
      p_err = 1; p_q = '0; p_r = '0;
      return;
    end
    q = a / b;
    r = a % b;
    if (s) p_err = (q > 32767) || (q < -32768);
    else   p_err = (q > 65535);
    p_q = q[15:0];
    p_r = r[15:0];
  endfunction

  always @(posedge clk) begin
    if (m_act) begin
      m_done = 0;
      if (!m_busy) begin
        if (start) begin
          expect_div(dvd, dvs, wide, sgn);
          m_busy = 1;
          m_left = 19;
        end
      end else if (!susp) begin
        m_left--;
        if (m_left == 0) begin
          m_busy = 0;
          m_done = 1;
          h_q = p_q; h_r = p_r; h_err = p_err; have = 1;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (m_act && !finished) begin
      chk("busy_o (R4)", busy, m_busy);
      chk("done_o (R4)", done, m_done);
      if (have) begin
        chk("err_o", err, h_err);
        if (!h_err) begin
          chk("quot_o", quot, h_q);
          chk("rem_o", rem, h_r);
        end
      end
    end
  end

  task automatic run(input logic [31:0] a, input logic [15:0] b, input bit w, input bit s,
                     input logic [31:0] smask, input bit extra, input string tag);
    cur_req = tag;
    @(negedge clk);
    dvd = a; dvs = b; wide = w; sgn = s; start = 1;
    @(negedge clk);
    start = 0;
    for (int i = 0; i < 60 && m_busy; i++) begin
      susp = smask[i % 32];
      if (extra && i < 4) begin
        start = 1; dvd = ~a; dvs = b + 16'd3; wide = ~w; sgn = ~s;
      end else begin
        start = 0;
      end
      @(negedge clk);
    end
    start = 0; susp = 0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic report();
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      report();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    cur_req = "R9";
    chk("reset busy_o", busy, 0);
    chk("reset done_o", done, 0);
    chk("reset err_o", err, 0);
    chk("reset quot_o", quot, 0);
    chk("reset rem_o", rem, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk("post-reset quot_o", quot, 0);
    chk("post-reset rem_o", rem, 0);
    m_act = 1;
    // R1 wide unsigned
    run(32'd1000000, 16'd7, 1, 0, 32'h0, 0, "R1");
    run(32'hFFFE0001, 16'hFFFF, 1, 0, 32'h0, 0, "R1");
    run(32'd12345, 16'd100, 1, 0, 32'h0, 0, "R1");
    // R2 narrow, upper half noise
    run(32'hABCD1234, 16'h0010, 0, 0, 32'h0, 0, "R2");
    run(32'h5555FF9C, 16'd7, 0, 1, 32'h0, 0, "R2");
    // R3 signed sign combinations
    run(-32'sd1000000, 16'd7, 1, 1, 32'h0, 0, "R3");
    run(32'd1000000, -16'sd7, 1, 1, 32'h0, 0, "R3");
    run(-32'sd100, -16'sd7, 1, 1, 32'h0, 0, "R3");
    run(32'd32768, -16'sd1, 1, 1, 32'h0, 0, "R3");
    // R5 suspension patterns
    run(32'd987654, 16'd321, 1, 0, 32'h0000_0F35, 0, "R5");
    run(-32'sd54321, 16'd77, 1, 1, 32'hA5A5_5A5A, 0, "R5");
    // R6 divide by zero
    run(32'd5, 16'd0, 1, 0, 32'h0, 0, "R6");
    // R7 overflow
    run(32'h00010000, 16'd1, 1, 0, 32'h0, 0, "R7");
    run(32'h00008000, -16'sd1, 0, 1, 32'h0, 0, "R7");
    run(32'd40000, 16'd1, 1, 1, 32'h0, 0, "R7");
    // R8 start during busy
    run(32'd77777, 16'd13, 1, 0, 32'h0000_0004, 1, "R8");
    // R9 hold while idle
    cur_req = "R9";
    repeat (5) @(negedge clk);
    report();
  end
endmodule